// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block models a single-clock synchronous static memory whose bus can change direction on every clock without an idle cycle between a read and a write. Address, command, chip selects and byte enables are registered on the rising edge. Read data flows straight from the array to the output during the cycle after the read address is registered. Write data trails its address by one edge. A one-entry pending-write buffer holds each write until the next enabled edge commits it, and any read that hits it sees the merged bytes.

A cycle-start input either loads a fresh address and command or advances a 2-bit burst counter that walks the two low address bits in linear or interleaved order. The other controls are an active-low clock enable that freezes the whole block, three chip selects of mixed polarity, a standby (snooze) input and an asynchronous active-low output drive. The data bus is split into an input port and an output port. The word count is set by `ADDR_W`. It defaults to 1K words so that elaboration stays small; set it to 16 for a 64K x 32 array.

Top module: `zbt_ft_sram`

## Requirements
- R1: A new cycle loads only when `step_nload` is 0 and all three selects are active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0). A load edge with any select inactive ends the active burst, and `rdata` then reads 0.
- R2: When a read (`rd_wrn`=1) is loaded at edge E, the addressed word appears on `rdata` in the cycle that follows E, with no further register stage.
- R3: The write data of a write loaded at edge E is sampled at the next enabled edge. Only lanes with `lane_we_n[k]`=0 are updated, where lane k is bits 8k+7:8k. The byte enables are sampled with the address.
- R4: Reads and writes may alternate on consecutive edges with no idle cycle, and every access gives the correct result.
- R5: A read issued on the edge right after a write to the same address returns the newly written bytes merged with the old unwritten bytes.
- R6: With `ilv_mode`=0 at the load edge, beat n of a burst uses low address bits (start + n) mod 4. The upper bits stay fixed.
- R7: With `ilv_mode`=1 at the load edge, beat n uses low address bits start XOR n.
- R8: `step_nload`=1 advances the burst and repeats its read or write type while ignoring the selects. When no burst is active it does nothing. The byte enables are resampled on each write beat.
- R9: While `clken_n`=1 the edge is ignored. Command, burst position, pending write and the write-data phase all hold.
- R10: `rd_drive_n`=1 forces `rdata` to 0 at once, even during a read.
- R11: `snooze`=1 at an enabled edge starts no cycle and ends any burst. The data phase of a write already loaded is still taken.
- R12: After reset no cycle is active, no write is pending and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clken_n | input | 1 | Active-low clock enable; high freezes the block |
| sel_a_n | input | 1 | Primary select, active low |
| sel_b | input | 1 | Depth select, active high |
| sel_c_n | input | 1 | Depth select, active low |
| step_nload | input | 1 | 1 advances the burst, 0 starts a new cycle |
| rd_wrn | input | 1 | 1 read, 0 write (sampled on load) |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | 4 | Active-low byte-lane write enables |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| snooze | input | 1 | Standby; new cycles ignored |
| rd_drive_n | input | 1 | Active-low output drive |
| wdata | input | 32 | Write data, one edge after its address |
| rdata | output | 32 | Flow-through read data, 0 when not driven |

## Verification
Embedded assertions check on every cycle that a suspended edge leaves command, burst position and pending write unchanged. They also check that an advance steps the counter by exactly one, that a deselecting or snoozing edge leaves no active cycle, and that each write data phase fills the pending buffer. The correctness of data across mixed bursts, partial-lane merges, read-after-write bypass and the two burst orders shows only in the bench's scenarios. There, a behavioural model of memory contents predicts every output word.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BURST_W = 2;

  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;

  // low address bits for beat 'cnt' of a burst starting at 'start'
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] cnt,
    input logic               ilv
  );
    if (ilv) return start ^ cnt;
    else     return start + cnt;
  endfunction
endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage import zbt_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int NLANE  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_ok,
  input  logic              sel,
  input  logic              step,
  input  logic              rd_wrn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NLANE-1:0]  lane_we_n,
  input  logic              ilv,
  input  logic              snooze,
  output logic              act,
  output op_e               op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [NLANE-1:0]  cur_be
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               ilv_q;

  // named events
  logic ev_load, ev_step, ev_end;
  assign ev_load = edge_ok && !snooze && !step && sel;
  assign ev_step = edge_ok && !snooze && step && act;
  assign ev_end  = edge_ok && (snooze || (!step && !sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      act    <= 1'b0;
      op     <= OP_READ;
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
      cur_be <= '0;
    end else if (ev_end) begin
      act <= 1'b0;
    end else if (ev_load) begin
      act    <= 1'b1;
      op     <= rd_wrn ? OP_READ : OP_WRITE;
      base_q <= addr;
      cnt_q  <= '0;
      ilv_q  <= ilv;
      cur_be <= ~lane_we_n;
    end else if (ev_step) begin
      cnt_q  <= cnt_q + 1'b1;
      cur_be <= ~lane_we_n;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:BURST_W], burst_low(base_q[BURST_W-1:0], cnt_q, ilv_q)};

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !edge_ok |=> $stable(act) && $stable(cnt_q) && $stable(base_q) && $stable(op));
  assert_step_R8: assert property (@(posedge clk) disable iff (rst)
    ev_step |=> act && (cnt_q == $past(cnt_q) + 2'd1) && $stable(base_q) && $stable(op));
  assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
    (edge_ok && !snooze && !step && !sel) |=> !act);
  assert_snooze_R11: assert property (@(posedge clk) disable iff (rst)
    (edge_ok && snooze) |=> !act);
endmodule

// File: rtl/zbt_late_write.sv
module zbt_late_write #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_ok,
  input  logic              wr_phase,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NLANE-1:0]  wr_be,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_q,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [NLANE-1:0]  commit_be,
  output logic [DATA_W-1:0] commit_data,
  output logic [DATA_W-1:0] rd_merged
);
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [NLANE-1:0]  be
  );
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int l = 0; l < NLANE; l++)
      if (be[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    return r;
  endfunction

  logic pend_q;
  logic rd_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      commit_addr <= '0;
      commit_be   <= '0;
      commit_data <= '0;
    end else if (edge_ok) begin
      pend_q <= wr_phase;
      if (wr_phase) begin
        commit_addr <= wr_addr;
        commit_be   <= wr_be;
        commit_data <= din;
      end
    end
  end

  assign commit_en = pend_q && edge_ok;
  assign rd_hit    = pend_q && (commit_addr == rd_addr);
  assign rd_merged = rd_hit ? lane_merge(array_q, commit_data, commit_be) : array_q;

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (edge_ok && wr_phase) |=> pend_q);
  assert_drain_R3: assert property (@(posedge clk) disable iff (rst)
    (edge_ok && !wr_phase) |=> !pend_q);
  assert_pend_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !edge_ok |=> $stable(pend_q) && $stable(commit_data) && $stable(commit_addr));
endmodule

// File: rtl/zbt_core_mem.sv
module zbt_core_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NLANE-1:0]  wbe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < NLANE; l++)
        if (wbe[l]) cells[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram import zbt_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clken_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              step_nload,
  input  logic              rd_wrn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NLANE-1:0]  lane_we_n,
  input  logic              ilv_mode,
  input  logic              snooze,
  input  logic              rd_drive_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic              edge_ok, sel_all;
  logic              act;
  op_e               op;
  logic [ADDR_W-1:0] cur_addr;
  logic [NLANE-1:0]  cur_be;
  logic              wr_phase, rd_phase;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [NLANE-1:0]  commit_be;
  logic [DATA_W-1:0] commit_data, array_q, rd_merged;

  assign edge_ok = !clken_n;
  assign sel_all = !sel_a_n && sel_b && !sel_c_n;

  zbt_cmd_stage #(.ADDR_W(ADDR_W), .NLANE(NLANE)) u_cmd (
    .clk(clk), .rst(rst), .edge_ok(edge_ok), .sel(sel_all), .step(step_nload),
    .rd_wrn(rd_wrn), .addr(addr), .lane_we_n(lane_we_n), .ilv(ilv_mode),
    .snooze(snooze), .act(act), .op(op), .cur_addr(cur_addr), .cur_be(cur_be)
  );

  assign wr_phase = act && (op == OP_WRITE);
  assign rd_phase = act && (op == OP_READ);

  zbt_late_write #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_wbuf (
    .clk(clk), .rst(rst), .edge_ok(edge_ok), .wr_phase(wr_phase),
    .wr_addr(cur_addr), .wr_be(cur_be), .din(wdata), .rd_addr(cur_addr),
    .array_q(array_q), .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_be(commit_be), .commit_data(commit_data), .rd_merged(rd_merged)
  );

  zbt_core_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .we(commit_en), .waddr(commit_addr), .wbe(commit_be),
    .wdata(commit_data), .raddr(cur_addr), .rdata(array_q)
  );

  assign rdata = (rd_phase && !rd_drive_n) ? rd_merged : '0;

  assert_reset_R12: assert property (@(posedge clk) rst |=> !act && (rdata == '0));
endmodule

// File: tb/tb_zbt_ft_sram.sv
module tb_zbt_ft_sram;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic clken_n = 0, sel_a_n = 1, sel_b = 0, sel_c_n = 1, step_nload = 0, rd_wrn = 1;
  logic [AW-1:0] addr = '0;
  logic [3:0] lane_we_n = 4'hF;
  logic ilv_mode = 0, snooze = 0, rd_drive_n = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  always #10 clk = ~clk;

  zbt_ft_sram #(.ADDR_W(AW)) dut (.*);

  // reference model state
  logic [31:0] mem [DEPTH];
  bit          known [DEPTH];
  bit          m_act, m_wr, m_ilv;
  int          m_base, m_cnt;
  logic [3:0]  m_be;
  int checks = 0, failures = 0;
  string cur_req = "R12";
  bit done = 0;

  function automatic int model_addr();
    int lo;
    lo = m_ilv ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) % 4);
    return (m_base & ~3) | lo;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_wr = 0; m_cnt = 0;
    end else if (!clken_n) begin
      if (m_act && m_wr) begin
        int a;
        a = model_addr();
        for (int k = 0; k < 4; k++)
          if (m_be[k]) mem[a][8*k +: 8] = wdata[8*k +: 8];
        if (m_be == 4'hF) known[a] = 1;
      end
      if (snooze) m_act = 0;
      else if (!step_nload) begin
        if (!sel_a_n && sel_b && !sel_c_n) begin
          m_act = 1; m_wr = !rd_wrn; m_base = int'(addr); m_cnt = 0;
          m_ilv = ilv_mode; m_be = ~lane_we_n;
        end else m_act = 0;
      end else if (m_act) begin
        m_cnt = (m_cnt + 1) % 4; m_be = ~lane_we_n;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (!done) begin
      logic [31:0] exp;
      bit ok;
      ok = 1;
      if (m_act && !m_wr && !rd_drive_n) begin
        ok = known[model_addr()];
        exp = mem[model_addr()];
      end else exp = '0;
      if (ok) begin
        checks++;
        if (rdata !== exp) begin
          failures++;
          $display("FAIL %s: rdata=%h expected=%h at %0t", cur_req, rdata, exp, $time);
        end
      end
    end
  end

  localparam logic [2:0] SEL = 3'b010;
  task automatic cyc(input logic [2:0] s, input logic stp, input logic rw,
                     input int a, input logic [3:0] wen, input logic [31:0] d);
    {sel_a_n, sel_b, sel_c_n} = s;
    step_nload = stp; rd_wrn = rw; addr = AW'(a); lane_we_n = wen; wdata = d;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    repeat (3) @(negedge clk);
    cur_req = "R12";
    rst = 0;
    cyc(3'b101, 0, 1, 0, 4'hF, 0);
    // fill: back-to-back writes, data follows address by one edge
    cur_req = "R3";
    for (int i = 0; i < 8; i++) cyc(SEL, 0, 0, i, 4'h0, (i == 0) ? 0 : 32'hA000_0000 + (i-1)*32'h1111);
    cyc(SEL, 0, 0, 32'h40, 4'h0, 32'hA000_0000 + 7*32'h1111);
    for (int i = 1; i < 8; i++) cyc(SEL, 0, 0, 32'h40 + i, 4'h0, 32'hB000_0000 + (i-1)*32'h0101);
    cyc(SEL, 0, 0, 32'h10, 4'h0, 32'hB000_0000 + 6*32'h0101);
    cyc(SEL, 0, 1, 5, 4'hF, 32'hC0DE_0010);
    // R4 alternate reads and writes, R5 read right after write to same addr
    cur_req = "R4";
    cyc(SEL, 0, 0, 6, 4'h0, 0);
    cyc(SEL, 0, 1, 6, 4'hF, 32'h1234_5678);
    cyc(SEL, 0, 0, 1, 4'h0, 0);
    cyc(SEL, 0, 1, 2, 4'hF, 32'h0BAD_F00D);
    cur_req = "R5";
    cyc(SEL, 0, 0, 3, 4'b1010, 0);
    cyc(SEL, 0, 1, 3, 4'hF, 32'hEEDD_CCBB);
    cyc(SEL, 0, 1, 3, 4'hF, 0);
    cyc(SEL, 0, 0, 3, 4'hF, 0);
    cyc(SEL, 0, 1, 3, 4'hF, 32'hFFFF_FFFF);
    // R6 linear burst read from 2
    cur_req = "R6";
    ilv_mode = 0;
    cyc(SEL, 0, 1, 2, 4'hF, 0);
    for (int i = 0; i < 3; i++) cyc(SEL, 1, 1, 0, 4'hF, 0);
    // R7 interleaved burst read from 0x41, mode changes mid burst ignored
    cur_req = "R7";
    ilv_mode = 1;
    cyc(SEL, 0, 1, 32'h41, 4'hF, 0);
    ilv_mode = 0;
    for (int i = 0; i < 3; i++) cyc(SEL, 1, 1, 0, 4'hF, 0);
    ilv_mode = 1;
    cyc(SEL, 0, 1, 32'h43, 4'hF, 0);
    for (int i = 0; i < 3; i++) cyc(SEL, 1, 1, 0, 4'hF, 0);
    // R8 write burst, selects off while advancing, per-beat lanes
    cur_req = "R8";
    ilv_mode = 0;
    cyc(SEL, 0, 0, 32'h45, 4'h0, 0);
    cyc(3'b101, 1, 1, 0, 4'b1100, 32'h1111_1111);
    cyc(3'b101, 1, 1, 0, 4'h0, 32'h2222_2222);
    cyc(3'b101, 1, 1, 0, 4'h0, 32'h3333_3333);
    cyc(SEL, 0, 1, 32'h44, 4'hF, 32'h4444_4444);
    for (int i = 0; i < 3; i++) cyc(SEL, 1, 1, 0, 4'hF, 0);
    // R1 deselect by each select alone, then advance with nothing active
    cur_req = "R1";
    cyc(3'b110, 0, 1, 2, 4'hF, 0);
    cyc(SEL, 0, 1, 2, 4'hF, 0);
    cyc(3'b000, 0, 1, 2, 4'hF, 0);
    cyc(SEL, 0, 1, 2, 4'hF, 0);
    cyc(3'b011, 0, 1, 2, 4'hF, 0);
    cur_req = "R8";
    cyc(SEL, 1, 0, 2, 4'h0, 0);
    cyc(SEL, 1, 0, 2, 4'h0, 32'h5555_5555);
    cyc(SEL, 0, 1, 2, 4'hF, 0);
    // R9 suspend mid read burst and between write address and data
    cur_req = "R9";
    cyc(SEL, 0, 1, 4, 4'hF, 0);
    clken_n = 1;
    cyc(SEL, 1, 0, 7, 4'h0, 32'h9999_9999);
    cyc(SEL, 0, 0, 1, 4'h0, 32'h9999_9999);
    clken_n = 0;
    cyc(SEL, 1, 1, 0, 4'hF, 0);
    cyc(SEL, 0, 0, 7, 4'h0, 0);
    clken_n = 1;
    cyc(SEL, 0, 1, 0, 4'hF, 32'h7777_7777);
    clken_n = 0;
    cyc(SEL, 0, 1, 7, 4'hF, 32'h6666_6666);
    // R10 output drive off during a read
    cur_req = "R10";
    rd_drive_n = 1;
    cyc(SEL, 0, 1, 7, 4'hF, 0);
    rd_drive_n = 0;
    cyc(SEL, 1, 1, 0, 4'hF, 0);
    // R11 snooze: ends read burst, write data phase still taken
    cur_req = "R11";
    cyc(SEL, 0, 0, 32'h10, 4'h0, 0);
    snooze = 1;
    cyc(SEL, 0, 0, 32'h11, 4'h0, 32'hFACE_CAFE);
    snooze = 0;
    cyc(SEL, 0, 1, 32'h10, 4'hF, 0);
    cyc(SEL, 0, 1, 32'h10, 4'hF, 0);
    snooze = 1;
    cyc(SEL, 1, 1, 0, 4'hF, 0);
    snooze = 0;
    cyc(SEL, 1, 1, 0, 4'hF, 0);
    // R2 single read then idle
    cur_req = "R2";
    cyc(SEL, 0, 1, 32'h46, 4'hF, 0);
    cyc(3'b101, 0, 1, 0, 4'hF, 0);
    cur_req = "R12";
    rst = 1;
    cyc(SEL, 0, 1, 1, 4'hF, 0);
    rst = 0;
    cyc(3'b101, 0, 1, 0, 4'hF, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule